// File: doc/BRIEF.md
# Torus Offset Routing Stage

This block is the per-hop steering stage of a switch in a three-dimensional torus. Each packet header holds a small signed hop count for each of the X, Y and Z dimensions, measured from the current node to the destination. The stage first checks the code that protects the header. It then picks one of seven output directions. Last, it moves the selected count one step closer to zero and builds a fresh check code over the changed header, so the next switch receives a consistent header.

Headers arrive on a valid/ready handshake and leave one cycle later from a single output register. That register holds its contents while the downstream side is not ready. The stage resolves the dimensions strictly in a fixed sequence: X must reach zero before Y is touched, and Y before Z. A header whose counts are all zero has arrived and is steered to the local port. A header whose incoming check code is wrong is dropped and reported on an error pulse.

Top module: `torus_route_stage`

## Requirements
- R1: The first non-zero count in the sequence X, then Y, then Z sets the direction. A positive count selects the plus port of that dimension and a negative count selects the minus port. The one-hot `out_port` uses bit 0 for +X, bit 1 for -X, bit 2 for +Y, bit 3 for -Y, bit 4 for +Z, bit 5 for -Z and bit 6 for local.
- R2: Only the selected count changes. It is decremented when positive and incremented when negative, and the other two counts leave unchanged.
- R3: A header whose three counts are all zero goes out on the local port (bit 6) with its counts unchanged.
- R4: The header is 12 bits. The X count sits in bits 3:0, Y in bits 7:4 and Z in bits 11:8, each a 4-bit two's-complement value. The extreme counts +7 and -8 are stepped like any other count.
- R5: The check code is CRC-8 with polynomial x^8+x^2+x+1 (0x07) and an initial value of zero. It runs over header bits 11 down to 0, most significant bit first, with no reflection and no final inversion. `out_crc` is this code computed over the outgoing header.
- R6: An accepted header whose `in_crc` does not match raises `err` for exactly one cycle, the cycle after acceptance. That header is not forwarded: `out_valid` stays low for it.
- R7: A header accepted at a clock edge (`in_valid` and `in_ready` both high) appears with `out_valid` high immediately after that edge.
- R8: While `out_valid` is high and `out_ready` is low, `out_port`, `out_hdr` and `out_crc` hold steady and `in_ready` is low. When `out_ready` is high, a new header can be accepted in the same cycle that the held one leaves.
- R9: After reset, `out_valid` and `err` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming header present |
| in_ready | output | 1 | Stage can take a header this cycle |
| in_hdr | input | 12 | Incoming header with three signed counts |
| in_crc | input | 8 | Check code that arrived with the header |
| out_valid | output | 1 | Outgoing header present |
| out_ready | input | 1 | Downstream takes the outgoing header |
| out_port | output | 7 | One-hot direction select |
| out_hdr | output | 12 | Header with the selected count stepped toward zero |
| out_crc | output | 8 | Check code rebuilt over out_hdr |
| err | output | 1 | One-cycle pulse for a dropped header with a bad code |

## Verification
The bench drives headers where several dimensions are non-zero at once. A stage with the wrong priority would steer along Y or Z too early, or step two counts in one hop. It also drives the extreme counts -8 and +7. A sign or overflow slip there would send -8 the wrong way or wrap it to +7 instead of -7. A header with a corrupted code must produce an error pulse and no output; a stage that forwarded it anyway would let a damaged header travel on. The stall test changes the input while the output is held. Any leak of the new header into the held outputs, or a lost header at the release edge, would show up there.

// File: rtl/torus_route_pkg.sv
package torus_route_pkg;
    localparam int DEF_OFF_W = 4;
    localparam int DEF_DIMS  = 3;
    localparam int DEF_CRC_W = 8;
    localparam logic [7:0] DEF_CRC_POLY = 8'h07;

    // Port index of the plus direction of a dimension; minus is one above.
    function automatic int plus_port(input int dim);
        return 2 * dim;
    endfunction

    // The local port follows all direction ports.
    function automatic int local_port(input int dims);
        return 2 * dims;
    endfunction
endpackage

// File: rtl/torus_crc.sv
module torus_crc #(
    parameter int          DW   = 12,
    parameter int          CW   = 8,
    parameter logic [CW-1:0] POLY = 8'h07
) (
    input  logic [DW-1:0] data_i,
    output logic [CW-1:0] crc_o
);
    logic [CW-1:0] acc;
    logic          fb;

    // Bit-serial division unrolled over the data word, most significant bit first.
    always_comb begin
        acc = '0;
        fb  = 1'b0;
        for (int i = DW - 1; i >= 0; i--) begin
            fb  = acc[CW-1] ^ data_i[i];
            acc = {acc[CW-2:0], 1'b0};
            if (fb) begin
                acc = acc ^ POLY;
            end
        end
        crc_o = acc;
    end
endmodule

// File: rtl/torus_dir_pick.sv
module torus_dir_pick
    import torus_route_pkg::*;
#(
    parameter int OFF_W = 4,
    parameter int DIMS  = 3,
    localparam int HW   = OFF_W * DIMS,
    localparam int PN   = 2 * DIMS + 1
) (
    input  logic [HW-1:0] hdr_i,
    output logic [PN-1:0] port_o,
    output logic [HW-1:0] hdr_o
);
    logic [DIMS-1:0] nonzero;
    logic [DIMS-1:0] negative;

    for (genvar g = 0; g < DIMS; g++) begin : g_dim
        assign nonzero[g]  = |hdr_i[g*OFF_W +: OFF_W];
        assign negative[g] = hdr_i[g*OFF_W + OFF_W - 1];
    end

    logic taken;

    always_comb begin
        port_o = '0;
        hdr_o  = hdr_i;
        taken  = 1'b0;
        for (int d = 0; d < DIMS; d++) begin
            if (!taken && nonzero[d]) begin
                taken = 1'b1;
                port_o[plus_port(d) + int'(negative[d])] = 1'b1;
                if (negative[d]) begin
                    hdr_o[d*OFF_W +: OFF_W] = hdr_i[d*OFF_W +: OFF_W] + OFF_W'(1);
                end else begin
                    hdr_o[d*OFF_W +: OFF_W] = hdr_i[d*OFF_W +: OFF_W] - OFF_W'(1);
                end
            end
        end
        if (!taken) begin
            port_o[local_port(DIMS)] = 1'b1;
        end
    end
endmodule

// File: rtl/torus_route_stage.sv
module torus_route_stage
    import torus_route_pkg::*;
#(
    parameter int OFF_W = DEF_OFF_W,
    parameter int DIMS  = DEF_DIMS,
    parameter int CRC_W = DEF_CRC_W,
    parameter logic [CRC_W-1:0] CRC_POLY = DEF_CRC_POLY,
    localparam int HDR_W = OFF_W * DIMS,
    localparam int PORT_N = 2 * DIMS + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [HDR_W-1:0]  in_hdr,
    input  logic [CRC_W-1:0]  in_crc,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PORT_N-1:0] out_port,
    output logic [HDR_W-1:0]  out_hdr,
    output logic [CRC_W-1:0]  out_crc,
    output logic              err
);
    typedef struct packed {
        logic              vld;
        logic [PORT_N-1:0] port;
        logic [HDR_W-1:0]  hdr;
        logic [CRC_W-1:0]  crc;
        logic              err;
    } stage_t;

    stage_t st_d, st_q;

    logic [CRC_W-1:0]  chk_in;
    logic [CRC_W-1:0]  chk_out;
    logic [PORT_N-1:0] pick_port;
    logic [HDR_W-1:0]  next_hdr;
    logic              crc_ok;
    logic              accept;

    torus_crc #(.DW(HDR_W), .CW(CRC_W), .POLY(CRC_POLY)) u_chk_in (
        .data_i (in_hdr),
        .crc_o  (chk_in)
    );

    torus_dir_pick #(.OFF_W(OFF_W), .DIMS(DIMS)) u_pick (
        .hdr_i  (in_hdr),
        .port_o (pick_port),
        .hdr_o  (next_hdr)
    );

    torus_crc #(.DW(HDR_W), .CW(CRC_W), .POLY(CRC_POLY)) u_chk_out (
        .data_i (next_hdr),
        .crc_o  (chk_out)
    );

    assign crc_ok   = (chk_in == in_crc);
    assign in_ready = !st_q.vld || out_ready;
    assign accept   = in_valid && in_ready;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (out_ready) begin
            st_d.vld = 1'b0;
        end
        if (accept) begin
            st_d.vld = crc_ok;
            st_d.err = !crc_ok;
            if (crc_ok) begin
                st_d.port = pick_port;
                st_d.hdr  = next_hdr;
                st_d.crc  = chk_out;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_port  = st_q.port;
    assign out_hdr   = st_q.hdr;
    assign out_crc   = st_q.crc;
    assign err       = st_q.err;

    assert_port_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_port) == 1));

    assert_local_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_port[local_port(DIMS)]) |-> (out_hdr == '0));

    assert_err_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !out_valid);

    assert_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && crc_ok) |=> out_valid);

    assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_port)
                                       && $stable(out_hdr) && $stable(out_crc)));
endmodule

// File: tb/sim_torus_route_stage.sv
module sim_torus_route_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [11:0] in_hdr = '0;
    logic [7:0]  in_crc = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [6:0]  out_port;
    logic [11:0] out_hdr;
    logic [7:0]  out_crc;
    logic        err;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    torus_route_stage u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_hdr(in_hdr), .in_crc(in_crc), .out_valid(out_valid),
        .out_ready(out_ready), .out_port(out_port), .out_hdr(out_hdr),
        .out_crc(out_crc), .err(err)
    );

    // {input header, expected port, expected output header}
    localparam int NV = 11;
    localparam logic [30:0] VEC [NV] = '{
        {12'h003, 7'h01, 12'h002},  // R1 R2 +X
        {12'h00D, 7'h02, 12'h00E},  // R1 R2 -X
        {12'h050, 7'h04, 12'h040},  // R1 +Y
        {12'h0F0, 7'h08, 12'h000},  // R1 -Y to zero
        {12'h700, 7'h10, 12'h600},  // R4 +7 on Z
        {12'h800, 7'h20, 12'h900},  // R4 -8 on Z
        {12'h000, 7'h40, 12'h000},  // R3 local
        {12'h971, 7'h01, 12'h970},  // R1 X before Y and Z
        {12'h980, 7'h08, 12'h990},  // R1 Y before Z, R4 -8 on Y
        {12'h007, 7'h01, 12'h006},  // R4 +7 on X
        {12'h008, 7'h02, 12'h009}   // R4 -8 on X
    };

    function automatic logic [7:0] ref_crc(input logic [11:0] h);
        logic [7:0] r = 8'h00;
        for (int k = 11; k >= 0; k--) begin
            logic top = r[7];
            r = r << 1;
            if (top != h[k]) r = r ^ 8'h07;
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [11:0] h, input logic [7:0] c);
        in_valid = 1'b1;
        in_hdr   = h;
        in_crc   = c;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 out_valid", 32'(out_valid), 32'd0);
        chk("R9 err", 32'(err), 32'd0);
        chk("R9 in_ready", 32'(in_ready), 32'd1);

        for (int i = 0; i < NV; i++) begin
            logic [11:0] h = VEC[i][30:19];
            logic [6:0]  p = VEC[i][18:12];
            logic [11:0] o = VEC[i][11:0];
            put(h, ref_crc(h));
            @(negedge clk);
            in_valid = 1'b0;
            chk("R7 out_valid", 32'(out_valid), 32'd1);
            chk("R1 out_port", 32'(out_port), 32'(p));
            chk("R2 out_hdr", 32'(out_hdr), 32'(o));
            chk("R5 out_crc", 32'(out_crc), 32'(ref_crc(o)));
            @(negedge clk);
        end

        // R6: corrupted code is dropped and flagged for one cycle
        put(12'h123, ref_crc(12'h123) ^ 8'h01);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R6 err pulse", 32'(err), 32'd1);
        chk("R6 no forward", 32'(out_valid), 32'd0);
        @(negedge clk);
        chk("R6 err clears", 32'(err), 32'd0);
        chk("R6 still nothing", 32'(out_valid), 32'd0);

        // R8: hold under stall, then release with back-to-back accept
        out_ready = 1'b0;
        put(12'h031, ref_crc(12'h031));
        @(negedge clk);
        put(12'h00F, ref_crc(12'h00F));
        chk("R8 in_ready low", 32'(in_ready), 32'd0);
        @(negedge clk);
        @(negedge clk);
        chk("R8 held valid", 32'(out_valid), 32'd1);
        chk("R8 held port", 32'(out_port), 32'h01);
        chk("R8 held hdr", 32'(out_hdr), 32'h030);
        chk("R8 held crc", 32'(out_crc), 32'(ref_crc(12'h030)));
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 next valid", 32'(out_valid), 32'd1);
        chk("R8 next port", 32'(out_port), 32'h02);
        chk("R8 next hdr", 32'(out_hdr), 32'h000);
        @(negedge clk);
        chk("R8 drained", 32'(out_valid), 32'd0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule